// File: doc/BRIEF.md
# Interrupt Claim Priority Arbiter

This block is the arbitration core of a platform interrupt controller. Level-sensitive interrupt lines come in from a number of sources. A number of targets, called contexts, each receive one notification line. For every source the block holds a pending flag that tracks the line, a claimed flag, and a 3-bit priority. For every context it holds an enable mask and a threshold. A source is eligible for a context when it is pending, not claimed, and enabled in that context's mask. The context's notification rises when an eligible source has a priority strictly above the context's threshold.

A context takes service by issuing a claim. The block answers with the ID of the best eligible source, and that source moves from pending to claimed. While claimed, the source is masked everywhere until a completion carrying its ID releases it. ID 0 is reserved and means "nothing to service". Bus decoding and register layout are handled outside the block. The block is reached through plain write ports for priority, enable and threshold, and through claim and completion ports.

Top module: `irq_claim_arbiter`

## Requirements
- R1: While `rst_n` is low, all pending, claimed, priority, enable and threshold state clears. `irq_out` and `claim_id` read 0 after reset.
- R2: A priority write to source `prio_id` (IDs 1 to NUM_SRC-1) stores only bits [2:0] of `prio_wdata`. Writes to ID 0 or to an ID at or above NUM_SRC change nothing.
- R3: On every clock, each source's pending flag takes the value of its `src_level` bit. Bit 0 of `src_level` is ignored, so source 0 is never pending.
- R4: `irq_out[c]` is registered. It equals 1 one clock after the state shows a source that is pending, not claimed, enabled in context c's mask, and has priority strictly greater than the threshold of context c.
- R5: A claim (`claim_req` high, context `claim_ctx`) loads `claim_id` at that clock edge with the eligible source that has the highest priority above the threshold. On a tie in priority, the lowest-numbered source wins. `claim_id` holds its value until the next claim.
- R6: A claim that finds no eligible source above the threshold loads `claim_id` with 0 and changes no pending or claimed state.
- R7: A successful claim clears the winner's pending flag and sets its claimed flag at the same edge. A claimed source is excluded from notification and from later claims.
- R8: A completion (`cmpl_we`) with `cmpl_id` below NUM_SRC clears that source's claimed flag. A completion with a larger ID is ignored.
- R9: A threshold write is accepted only when `thr_wdata` is at most MAX_PRIO (default 7). Otherwise the context keeps its old threshold.
- R10: If a claim wins a source in the same cycle that a completion names that same source, the completion takes effect after the claim, so the source ends up unclaimed.
- R11: An enable write replaces the whole mask of context `en_ctx` with `en_wdata`. Bit i enables source i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| src_level | input | NUM_SRC | Interrupt line levels, bit i for source i |
| prio_we | input | 1 | Priority write strobe |
| prio_id | input | ID_W | Source whose priority is written |
| prio_wdata | input | WDATA_W | Priority write value; low 3 bits kept |
| en_we | input | 1 | Enable mask write strobe |
| en_ctx | input | CTX_W | Context whose mask is written |
| en_wdata | input | NUM_SRC | New enable mask |
| thr_we | input | 1 | Threshold write strobe |
| thr_ctx | input | CTX_W | Context whose threshold is written |
| thr_wdata | input | WDATA_W | Threshold write value |
| claim_req | input | 1 | Claim strobe |
| claim_ctx | input | CTX_W | Claiming context |
| claim_id | output | ID_W | Result of the last claim, 0 if none |
| cmpl_we | input | 1 | Completion strobe |
| cmpl_id | input | ID_W | Source ID being completed |
| irq_out | output | NUM_CTX | Per-context notification |

## Verification
A level change or a write lands in state at the next edge. Its effect on `irq_out` appears one edge later, so `irq_out` lags its cause by two edges. A claim or completion changes `claim_id` and the pending and claimed flags at the edge that samples it. The bench drives inputs on falling edges and samples outputs on falling edges. Its reference model keeps the same two-stage timing: it computes notification from the state before each rising edge and then updates the state, so every cycle's `irq_out` and `claim_id` are compared with the value due in that cycle. Directed claims read `claim_id` on the falling edge right after the claiming edge. Directed notification checks wait one more edge.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;

  // Priority and threshold width is fixed by the block's definition.
  localparam int PRIO_W = 3;

  // Width of a selector over n items, never below one bit.
  function automatic int sel_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/irqarb_src_bank.sv
module irqarb_src_bank #(
  parameter int NUM_SRC = 32,
  parameter int ID_W    = 6,
  parameter int PRIO_W  = 3,
  parameter int WDATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_level,
  input  logic                      prio_we,
  input  logic [ID_W-1:0]           prio_id,
  input  logic [WDATA_W-1:0]        prio_wdata,
  input  logic [NUM_SRC-1:0]        claim_set,
  input  logic [NUM_SRC-1:0]        cmpl_clr,
  output logic [NUM_SRC-1:0]        pend_o,
  output logic [NUM_SRC-1:0]        claimed_o,
  output logic [NUM_SRC*PRIO_W-1:0] prio_o
);

  // Source 0 carries no state; its inputs and the upper write bits are dropped.
  logic unused_bits;
  assign unused_bits = ^{src_level[0], claim_set[0], cmpl_clr[0],
                         prio_wdata[WDATA_W-1:PRIO_W]};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i == 0) begin : g_rsvd
      assign pend_o[i]                  = 1'b0;
      assign claimed_o[i]               = 1'b0;
      assign prio_o[i*PRIO_W +: PRIO_W] = '0;
    end else begin : g_live
      logic              pend_d, pend_q;
      logic              clm_d, clm_q;
      logic              prio_en;
      logic [PRIO_W-1:0] prio_d, prio_q;

      // Claim first, completion second: a same-cycle completion wins.
      always_comb begin
        pend_d  = src_level[i] & ~claim_set[i];
        clm_d   = (clm_q | claim_set[i]) & ~cmpl_clr[i];
        prio_en = prio_we && (prio_id == ID_W'(i));
        prio_d  = prio_wdata[PRIO_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q <= 1'b0;
          clm_q  <= 1'b0;
          prio_q <= '0;
        end else begin
          pend_q <= pend_d;
          clm_q  <= clm_d;
          if (prio_en) prio_q <= prio_d;
        end
      end

      assign pend_o[i]                  = pend_q;
      assign claimed_o[i]               = clm_q;
      assign prio_o[i*PRIO_W +: PRIO_W] = prio_q;
    end
  end

endmodule

// File: rtl/irqarb_ctx_bank.sv
module irqarb_ctx_bank #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CTX  = 2,
  parameter int CTX_W    = 1,
  parameter int PRIO_W   = 3,
  parameter int WDATA_W  = 8,
  parameter int MAX_PRIO = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en_we,
  input  logic [CTX_W-1:0]           en_ctx,
  input  logic [NUM_SRC-1:0]         en_wdata,
  input  logic                       thr_we,
  input  logic [CTX_W-1:0]           thr_ctx,
  input  logic [WDATA_W-1:0]         thr_wdata,
  output logic [NUM_CTX*NUM_SRC-1:0] en_o,
  output logic [NUM_CTX*PRIO_W-1:0]  thr_o
);

  logic thr_ok;
  assign thr_ok = (thr_wdata <= WDATA_W'(MAX_PRIO));

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic               en_ld, thr_ld;
    logic [NUM_SRC-1:0] en_q;
    logic [PRIO_W-1:0]  thr_q;

    always_comb begin
      en_ld  = en_we && (en_ctx == CTX_W'(c));
      thr_ld = thr_we && thr_ok && (thr_ctx == CTX_W'(c));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q  <= '0;
        thr_q <= '0;
      end else begin
        if (en_ld)  en_q  <= en_wdata;
        if (thr_ld) thr_q <= thr_wdata[PRIO_W-1:0];
      end
    end

    assign en_o[c*NUM_SRC +: NUM_SRC] = en_q;
    assign thr_o[c*PRIO_W +: PRIO_W]  = thr_q;
  end

endmodule

// File: rtl/irqarb_pick.sv
module irqarb_pick #(
  parameter int NUM_SRC = 32,
  parameter int ID_W    = 6,
  parameter int PRIO_W  = 3
) (
  input  logic [NUM_SRC-1:0]        elig,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]         thr,
  output logic                      hit,
  output logic [ID_W-1:0]           best_id
);

  logic unused_bits;
  assign unused_bits = ^{elig[0], prio[PRIO_W-1:0]};

  logic [PRIO_W-1:0] best_p;

  // Ascending scan with a strict compare keeps the lowest ID on ties.
  always_comb begin
    best_p  = thr;
    best_id = '0;
    hit     = 1'b0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (elig[i] && (prio[i*PRIO_W +: PRIO_W] > best_p)) begin
        best_p  = prio[i*PRIO_W +: PRIO_W];
        best_id = ID_W'(i);
        hit     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_claim_arbiter.sv
module irq_claim_arbiter
  import irqarb_pkg::*;
#(
  parameter int  NUM_SRC  = 32,
  parameter int  NUM_CTX  = 2,
  parameter int  WDATA_W  = 8,
  parameter int  MAX_PRIO = 7,
  localparam int ID_W     = $clog2(NUM_SRC + 1),
  localparam int CTX_W    = sel_bits(NUM_CTX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic               prio_we,
  input  logic [ID_W-1:0]    prio_id,
  input  logic [WDATA_W-1:0] prio_wdata,
  input  logic               en_we,
  input  logic [CTX_W-1:0]   en_ctx,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic               thr_we,
  input  logic [CTX_W-1:0]   thr_ctx,
  input  logic [WDATA_W-1:0] thr_wdata,
  input  logic               claim_req,
  input  logic [CTX_W-1:0]   claim_ctx,
  output logic [ID_W-1:0]    claim_id,
  input  logic               cmpl_we,
  input  logic [ID_W-1:0]    cmpl_id,
  output logic [NUM_CTX-1:0] irq_out
);

  logic [NUM_SRC-1:0]         pend_w, claimed_w, claim_set, cmpl_clr;
  logic [NUM_SRC*PRIO_W-1:0]  prio_w;
  logic [NUM_CTX*NUM_SRC-1:0] en_w;
  logic [NUM_CTX*PRIO_W-1:0]  thr_w;
  logic [NUM_CTX-1:0]         hit_vec;
  logic [NUM_CTX*ID_W-1:0]    best_flat;
  logic                       claim_hit, claim_fire, cmpl_ok;
  logic [ID_W-1:0]            sel_id, claim_d, claim_q;
  logic [NUM_CTX-1:0]         irq_q;

  irqarb_src_bank #(
    .NUM_SRC(NUM_SRC), .ID_W(ID_W), .PRIO_W(PRIO_W), .WDATA_W(WDATA_W)
  ) u_src (
    .clk(clk), .rst_n(rst_n), .src_level(src_level),
    .prio_we(prio_we), .prio_id(prio_id), .prio_wdata(prio_wdata),
    .claim_set(claim_set), .cmpl_clr(cmpl_clr),
    .pend_o(pend_w), .claimed_o(claimed_w), .prio_o(prio_w)
  );

  irqarb_ctx_bank #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .PRIO_W(PRIO_W),
    .WDATA_W(WDATA_W), .MAX_PRIO(MAX_PRIO)
  ) u_ctx (
    .clk(clk), .rst_n(rst_n),
    .en_we(en_we), .en_ctx(en_ctx), .en_wdata(en_wdata),
    .thr_we(thr_we), .thr_ctx(thr_ctx), .thr_wdata(thr_wdata),
    .en_o(en_w), .thr_o(thr_w)
  );

  // One selection network per context, all working from the same state.
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_pick
    logic [NUM_SRC-1:0] elig;
    assign elig = pend_w & ~claimed_w & en_w[c*NUM_SRC +: NUM_SRC];

    irqarb_pick #(
      .NUM_SRC(NUM_SRC), .ID_W(ID_W), .PRIO_W(PRIO_W)
    ) u_pick (
      .elig(elig), .prio(prio_w), .thr(thr_w[c*PRIO_W +: PRIO_W]),
      .hit(hit_vec[c]), .best_id(best_flat[c*ID_W +: ID_W])
    );
  end

  // Route the claiming context's winner.
  always_comb begin
    claim_hit = 1'b0;
    sel_id    = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (claim_ctx == CTX_W'(c)) begin
        claim_hit = hit_vec[c];
        sel_id    = best_flat[c*ID_W +: ID_W];
      end
    end
  end

  always_comb begin
    claim_fire = claim_req & claim_hit;
    claim_set  = claim_fire ? (NUM_SRC'(1) << sel_id) : '0;
    cmpl_ok    = cmpl_we && (cmpl_id < ID_W'(NUM_SRC));
    cmpl_clr   = cmpl_ok ? (NUM_SRC'(1) << cmpl_id) : '0;
    claim_d    = claim_fire ? sel_id : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim_q <= '0;
      irq_q   <= '0;
    end else begin
      if (claim_req) claim_q <= claim_d;
      irq_q <= hit_vec;
    end
  end

  assign claim_id = claim_q;
  assign irq_out  = irq_q;

endmodule

// File: rtl/irqarb_chk.sv
module irqarb_chk #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CTX  = 2,
  parameter int ID_W     = 6,
  parameter int PRIO_W   = 3,
  parameter int WDATA_W  = 8,
  parameter int MAX_PRIO = 7
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      claim_req,
  input logic                      claim_hit,
  input logic [ID_W-1:0]           claim_id,
  input logic                      cmpl_we,
  input logic [ID_W-1:0]           cmpl_id,
  input logic                      thr_we,
  input logic [WDATA_W-1:0]        thr_wdata,
  input logic [NUM_SRC-1:0]        pend,
  input logic [NUM_SRC-1:0]        claimed,
  input logic [NUM_CTX*PRIO_W-1:0] thr_flat,
  input logic [NUM_CTX-1:0]        hit_vec,
  input logic [NUM_CTX-1:0]        irq_out
);

  logic [NUM_SRC-1:0] won_sel;
  assign won_sel = NUM_SRC'(1) << claim_id;

  // R7: winner reported, pending dropped, claimed unless completed alongside
  a_r7_claim_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_req && claim_hit) |=>
      (claim_id != '0) && !(|(pend & won_sel)) &&
      ((|(claimed & won_sel)) || $past(cmpl_we)));

  // R6: empty claim reports zero
  a_r6_empty_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_req && !claim_hit) |=> (claim_id == '0));

  // R8: in-range completion releases the source
  a_r8_cmpl_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_we && (cmpl_id < ID_W'(NUM_SRC))) |=>
      !(|(claimed & (NUM_SRC'(1) << $past(cmpl_id)))));

  // R9: oversize threshold write leaves every threshold unchanged
  a_r9_thr_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_we && (thr_wdata > WDATA_W'(MAX_PRIO))) |=> $stable(thr_flat));

  // R4: notification is the selection result registered one clock later
  a_r4_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |=> (irq_out == $past(hit_vec)));

  a_r4_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec == '0) |=> (irq_out == '0));

endmodule

bind irq_claim_arbiter irqarb_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ID_W(ID_W), .PRIO_W(PRIO_W),
  .WDATA_W(WDATA_W), .MAX_PRIO(MAX_PRIO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .claim_req(claim_req), .claim_hit(claim_hit),
  .claim_id(claim_id), .cmpl_we(cmpl_we), .cmpl_id(cmpl_id),
  .thr_we(thr_we), .thr_wdata(thr_wdata), .pend(pend_w),
  .claimed(claimed_w), .thr_flat(thr_w), .hit_vec(hit_vec), .irq_out(irq_out)
);

// File: tb/sim_irq_claim_arbiter.sv
module sim_irq_claim_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NS   = 32;
  localparam int NC   = 2;
  localparam int IDW  = 6;
  localparam int CTXW = 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS-1:0]   src_level = '0;
  logic            prio_we = 1'b0;
  logic [IDW-1:0]  prio_id = '0;
  logic [7:0]      prio_wdata = '0;
  logic            en_we = 1'b0;
  logic [CTXW-1:0] en_ctx = '0;
  logic [NS-1:0]   en_wdata = '0;
  logic            thr_we = 1'b0;
  logic [CTXW-1:0] thr_ctx = '0;
  logic [7:0]      thr_wdata = '0;
  logic            claim_req = 1'b0;
  logic [CTXW-1:0] claim_ctx = '0;
  logic [IDW-1:0]  claim_id;
  logic            cmpl_we = 1'b0;
  logic [IDW-1:0]  cmpl_id = '0;
  logic [NC-1:0]   irq_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_claim_arbiter #(.NUM_SRC(NS), .NUM_CTX(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .src_level(src_level),
    .prio_we(prio_we), .prio_id(prio_id), .prio_wdata(prio_wdata),
    .en_we(en_we), .en_ctx(en_ctx), .en_wdata(en_wdata),
    .thr_we(thr_we), .thr_ctx(thr_ctx), .thr_wdata(thr_wdata),
    .claim_req(claim_req), .claim_ctx(claim_ctx), .claim_id(claim_id),
    .cmpl_we(cmpl_we), .cmpl_id(cmpl_id), .irq_out(irq_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int       m_prio[NS];
  bit       m_pend[NS];
  bit       m_clm[NS];
  bit [NS-1:0] m_en[NC];
  int       m_thr[NC];
  int       m_irq;
  int       m_claim;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin m_prio[i] = 0; m_pend[i] = 0; m_clm[i] = 0; end
      for (int c = 0; c < NC; c++) begin m_en[c] = '0; m_thr[c] = 0; end
      m_irq = 0; m_claim = 0;
    end else begin
      int best[NC];
      int winner;
      m_irq = 0;
      for (int c = 0; c < NC; c++) begin
        int bp;
        bp = m_thr[c]; best[c] = 0;
        for (int i = 1; i < NS; i++)
          if (m_pend[i] && !m_clm[i] && m_en[c][i] && m_prio[i] > bp) begin
            bp = m_prio[i]; best[c] = i;
          end
        if (best[c] != 0) m_irq |= (1 << c);
      end
      winner = 0;
      if (claim_req) begin
        if (int'(claim_ctx) < NC) winner = best[claim_ctx];
        m_claim = winner;
      end
      for (int i = 1; i < NS; i++) m_pend[i] = src_level[i] && (i != winner);
      if (winner != 0) m_clm[winner] = 1;
      if (cmpl_we && int'(cmpl_id) < NS) m_clm[cmpl_id] = 0;
      if (prio_we && prio_id >= 1 && int'(prio_id) < NS) m_prio[prio_id] = prio_wdata & 7;
      if (en_we && int'(en_ctx) < NC) m_en[en_ctx] = en_wdata;
      if (thr_we && int'(thr_ctx) < NC && thr_wdata <= 7) m_thr[thr_ctx] = thr_wdata;
    end
  end

  // Every-cycle comparison, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(irq_out == NC'(m_irq), "R4 irq_out vs model", irq_out, m_irq);
      chk(claim_id == IDW'(m_claim), "R5 claim_id vs model", claim_id, m_claim);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_prio(input int id, input int v);
    @(negedge clk); prio_we = 1; prio_id = IDW'(id); prio_wdata = 8'(v);
    @(negedge clk); prio_we = 0;
  endtask

  task automatic set_en(input int c, input logic [NS-1:0] m);
    @(negedge clk); en_we = 1; en_ctx = CTXW'(c); en_wdata = m;
    @(negedge clk); en_we = 0;
  endtask

  task automatic set_thr(input int c, input int v);
    @(negedge clk); thr_we = 1; thr_ctx = CTXW'(c); thr_wdata = 8'(v);
    @(negedge clk); thr_we = 0;
  endtask

  task automatic complete(input int id);
    @(negedge clk); cmpl_we = 1; cmpl_id = IDW'(id);
    @(negedge clk); cmpl_we = 0;
  endtask

  task automatic claim(input int c, input int cmpl, output int id);
    @(negedge clk); claim_req = 1; claim_ctx = CTXW'(c);
    if (cmpl >= 0) begin cmpl_we = 1; cmpl_id = IDW'(cmpl); end
    @(negedge clk); claim_req = 0; cmpl_we = 0;
    id = int'(claim_id);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int id;
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    chk(irq_out == '0, "R1 irq after reset", irq_out, 0);
    chk(claim_id == '0, "R1 claim_id after reset", claim_id, 0);

    set_prio(5, 8'h0B);          // kept as 3
    set_prio(9, 3);
    set_prio(12, 6);
    set_prio(0, 7);              // reserved ID, no effect
    set_en(0, (NS'(1) << 0) | (NS'(1) << 5) | (NS'(1) << 9) | (NS'(1) << 12));
    set_thr(0, 2);

    src_level = NS'(1);          // only source 0
    cyc(3);
    chk(irq_out[0] == 1'b0, "R3 source 0 ignored", irq_out[0], 0);

    src_level = (NS'(1) << 5) | (NS'(1) << 9) | (NS'(1) << 12) | NS'(1);
    cyc(2);
    chk(irq_out[0] == 1'b1, "R4 ctx0 notified", irq_out[0], 1);
    chk(irq_out[1] == 1'b0, "R11 ctx1 empty mask", irq_out[1], 0);

    claim(0, -1, id); chk(id == 12, "R5 highest priority", id, 12);
    claim(0, -1, id); chk(id == 5,  "R2 R5 low bits kept, tie to lowest", id, 5);
    claim(0, -1, id); chk(id == 9,  "R5 next in order", id, 9);
    claim(0, -1, id); chk(id == 0,  "R6 nothing left", id, 0);
    cyc(2);
    chk(irq_out[0] == 1'b0, "R7 claimed sources masked", irq_out[0], 0);

    complete(40);
    claim(0, -1, id); chk(id == 0,  "R8 out-of-range completion ignored", id, 0);
    complete(12);
    claim(0, -1, id); chk(id == 12, "R8 completion releases", id, 12);

    complete(12);
    claim(0, 12, id); chk(id == 12, "R10 claim with same-cycle completion", id, 12);
    claim(0, -1, id); chk(id == 12, "R10 source left unclaimed", id, 12);

    complete(12);
    set_thr(0, 6);
    claim(0, -1, id); chk(id == 0,  "R9 threshold 6 masks priority 6", id, 0);
    set_thr(0, 8);
    claim(0, -1, id); chk(id == 0,  "R9 oversize threshold rejected", id, 0);
    set_thr(0, 5);
    claim(0, -1, id); chk(id == 12, "R9 threshold 5 accepted", id, 12);

    complete(5); complete(9);
    set_en(1, NS'(1) << 9);
    cyc(2);
    chk(irq_out[1] == 1'b1, "R11 ctx1 mask loaded", irq_out[1], 1);
    set_en(1, NS'(1) << 3);
    cyc(2);
    chk(irq_out[1] == 1'b0, "R11 ctx1 mask replaced", irq_out[1], 0);

    // Mixed traffic checked by the model every cycle.
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      src_level  = $urandom;
      claim_req  = ($urandom % 3) == 0;
      claim_ctx  = CTXW'($urandom % NC);
      cmpl_we    = ($urandom % 3) == 0;
      cmpl_id    = IDW'($urandom % 40);
      prio_we    = ($urandom % 4) == 0;
      prio_id    = IDW'($urandom % 36);
      prio_wdata = 8'($urandom);
      en_we      = ($urandom % 16) == 0;
      en_ctx     = CTXW'($urandom % NC);
      en_wdata   = $urandom;
      thr_we     = ($urandom % 12) == 0;
      thr_ctx    = CTXW'($urandom % NC);
      thr_wdata  = 8'($urandom % 12);
    end
    @(negedge clk);
    claim_req = 0; cmpl_we = 0; prio_we = 0; en_we = 0; thr_we = 0;
    cyc(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule